// File: doc/BRIEF.md
# Packed-BCD Calendar Clock with Hourly Drift Trim

This block keeps wall-clock time and date as packed-BCD values. The six values are seconds, minutes, hours (24-hour), day of month, month and a two-digit year that stands for 2000 to 2099. A sub-second prescaler counts enabled ticks of a slow timebase, nominally 32768 per second, and advances the calendar once per second. The calendar handles month lengths and leap years.

The host reaches the block through a byte-wide register port with combinational reads. The live counters are never read directly. The host requests a snapshot, and reads of the time registers return the frozen copy, so a multi-byte read cannot tear across a carry. To set the time, the host stops the clock, writes the six values and starts it again.

A signed 16-bit trim value corrects crystal drift. When trimming is enabled, the prescaler restarts at the trim value instead of zero once an hour, on the second step from 00 to 01 with minutes at 00. A positive trim shortens that second and a negative trim lengthens it.

Top module: `bcd_rtc`

## Requirements
- R1: While running, the seconds value advances once for every TICKS_PER_SEC clock cycles in which tick_en is high. Cycles with tick_en low do not count.
- R2: Seconds and minutes count in BCD and wrap from 59 to 00, carrying into the next field. Hours wrap from 23 to 00 and carry into the day.
- R3: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. February ends at 29 when the binary year is a multiple of 4 and at 28 otherwise.
- R4: Month counts 01 to 12 and wraps to 01, carrying into the year. Year counts 00 to 99 and wraps to 00.
- R5: Address 6 is control: bit0 is run, bit1 is snapshot request, bit2 is trim enable, and bits 7:3 read as 0. While run is 0 the prescaler and calendar hold. Writes to addresses 0 to 5 (seconds, minutes, hours, day, month, year, in that order) load the live calendar only while run is 0 and are ignored while run is 1.
- R6: Writing control with bit1 set raises the request. On the next edge the six live values are copied into the snapshot and the request clears. Reads of addresses 0 to 5 return the snapshot, and control bit1 reads back the pending request.
- R7: A write to address 7 stages the low trim byte. A write to address 8 commits {data, staged byte} as the trim, unless that value is 16'h7FFF, in which case the old trim is kept. Addresses 7 and 8 read the committed trim's low and high bytes. Unused addresses read 0.
- R8: With trim enabled, when the seconds step from 00 to 01 while minutes are 00, the prescaler reloads with the sign-extended trim instead of 0. The next second then lasts TICKS_PER_SEC minus trim enabled ticks, or a single tick when the trim is TICKS_PER_SEC-1 or more. With trim disabled the reload is always 0.
- R9: After reset the clock is stopped, the time is 00:00:00 on day 01, month 01, year 00, the snapshot holds the same values, and the trim, the staged byte and the control bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per timebase tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Combinational register read data |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4. With that setting a second lasts only a handful of cycles, and a trim of +2, -3 or 16'h7FFE changes the length of the trimmed second by a visible number of cycles. Presetting the time a few seconds before year end, before each month length and before the top of an hour brings each rollover and each hourly trim event within a few dozen cycles. Because the snapshot is requested every other cycle, any off-by-one in when a carry or a trimmed second happens shows up directly in the read data.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam int PW = ($clog2(TICKS_PER_SEC) > 16) ? $clog2(TICKS_PER_SEC) + 2 : 18;
  localparam logic signed [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] inc_bcd(input logic [7:0] b);
    return (b[3:0] == 4'd9) ? {b[7:4] + 4'd1, 4'd0} : {b[7:4], b[3:0] + 4'd1};
  endfunction

  logic signed [PW-1:0] presc;
  logic [7:0] sec, mins, hrs, day, mon, yr;
  logic [7:0] snap_sec, snap_min, snap_hr, snap_day, snap_mon, snap_yr;
  logic run, snap_req, auto_comp;
  logic [15:0] comp_val;
  logic [7:0] comp_stage;
  logic adv, comp_hit, sec_w, min_w, hr_w, day_w, mon_w, comp_ok;
  int dmax;

  assign adv      = run && tick_en && (presc >= LAST);
  assign comp_hit = auto_comp && (mins == 8'h00) && (sec == 8'h00);
  assign sec_w    = (sec == 8'h59);
  assign min_w    = (mins == 8'h59);
  assign hr_w     = (hrs == 8'h23);
  assign day_w    = (b2i(day) == dmax);
  assign mon_w    = (mon == 8'h12);
  assign comp_ok  = ({wr_data, comp_stage} != 16'h7FFF);

  always_comb begin
    case (mon)
      8'h02:                      dmax = ((b2i(yr) % 4) == 0) ? 29 : 28;
      8'h04, 8'h06, 8'h09, 8'h11: dmax = 30;
      default:                    dmax = 31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      sec <= 8'h00; mins <= 8'h00; hrs <= 8'h00;
      day <= 8'h01; mon <= 8'h01; yr <= 8'h00;
      snap_sec <= 8'h00; snap_min <= 8'h00; snap_hr <= 8'h00;
      snap_day <= 8'h01; snap_mon <= 8'h01; snap_yr <= 8'h00;
      run <= 1'b0; snap_req <= 1'b0; auto_comp <= 1'b0;
      comp_val <= '0; comp_stage <= '0;
    end else begin
      if (snap_req) begin
        snap_sec <= sec; snap_min <= mins; snap_hr <= hrs;
        snap_day <= day; snap_mon <= mon; snap_yr <= yr;
        snap_req <= 1'b0;
      end
      if (run && tick_en)
        presc <= !adv ? presc + PW'(1) :
                 comp_hit ? {{(PW-16){comp_val[15]}}, comp_val} : '0;
      if (adv) begin
        sec <= sec_w ? 8'h00 : inc_bcd(sec);
        if (sec_w) begin
          mins <= min_w ? 8'h00 : inc_bcd(mins);
          if (min_w) begin
            hrs <= hr_w ? 8'h00 : inc_bcd(hrs);
            if (hr_w) begin
              day <= day_w ? 8'h01 : inc_bcd(day);
              if (day_w) begin
                mon <= mon_w ? 8'h01 : inc_bcd(mon);
                if (mon_w) yr <= (yr == 8'h99) ? 8'h00 : inc_bcd(yr);
              end
            end
          end
        end
      end
      if (wr_en) begin
        case (addr)
          4'd0: if (!run) sec  <= wr_data;
          4'd1: if (!run) mins <= wr_data;
          4'd2: if (!run) hrs  <= wr_data;
          4'd3: if (!run) day  <= wr_data;
          4'd4: if (!run) mon  <= wr_data;
          4'd5: if (!run) yr   <= wr_data;
          4'd6: begin
            run       <= wr_data[0];
            auto_comp <= wr_data[2];
            if (wr_data[1]) snap_req <= 1'b1;
          end
          4'd7: comp_stage <= wr_data;
          4'd8: if (comp_ok) comp_val <= {wr_data, comp_stage};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rd_data = snap_sec;
      4'd1:    rd_data = snap_min;
      4'd2:    rd_data = snap_hr;
      4'd3:    rd_data = snap_day;
      4'd4:    rd_data = snap_mon;
      4'd5:    rd_data = snap_yr;
      4'd6:    rd_data = {5'b0, auto_comp, snap_req, run};
      4'd7:    rd_data = comp_val[7:0];
      4'd8:    rd_data = comp_val[15:8];
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic [7:0]  wr_data,
  input logic        run,
  input logic        snap_req,
  input logic [15:0] comp_val,
  input logic [7:0]  comp_stage,
  input logic [7:0]  sec,
  input logic [7:0]  mins,
  input logic [7:0]  hrs,
  input logic [7:0]  day,
  input logic [7:0]  mon,
  input logic [7:0]  yr,
  input logic [7:0]  snap_sec,
  input logic        adv
);
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n) adv && sec == 8'h59 |=> sec == 8'h00); // R2
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n) adv && sec[3:0] < 4'd9 && sec != 8'h59 |=> sec == $past(sec) + 8'd1); // R2
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run && !wr_en |=> $stable({sec, mins, hrs, day, mon, yr})); // R5
  AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) run && !tick_en && wr_en && addr <= 4'd5 |=> $stable({sec, mins, hrs, day, mon, yr})); // R5
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n) snap_req |=> snap_sec == $past(sec)); // R6
  AST_SNAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) snap_req && !(wr_en && addr == 4'd6 && wr_data[1]) |=> !snap_req); // R6
  AST_COMP_REJECT: assert property (@(posedge clk) disable iff (!rst_n) wr_en && addr == 4'd8 && {wr_data, comp_stage} == 16'h7FFF |=> $stable(comp_val)); // R7
endmodule

bind bcd_rtc rtc_chk u_rtc_chk (.*);

// File: tb/tb_bcd_rtc.sv
`timescale 1ns/1ps
module tb_bcd_rtc;
  localparam int TPS = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  bcd_rtc #(.TICKS_PER_SEC(TPS)) dut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, tcount = 0, tick_gap = 0, rot = 0;
  bit cmp_on = 0, done = 0, b_run = 0, b_auto = 0;
  string cur_req = "R9";

  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_cnt, m_comp;
  int s_sec, s_min, s_hr, s_day, s_mon, s_yr;
  bit m_run, m_auto, m_snapreq;
  logic [7:0] m_stage;

  function automatic int mdays(int m, int y);
    case (m)
      2: return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [7:0] tobcd(int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction

  function automatic int frombcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_cnt = 0; m_comp = 0;
      s_sec = 0; s_min = 0; s_hr = 0; s_day = 1; s_mon = 1; s_yr = 0;
      m_run = 0; m_auto = 0; m_snapreq = 0; m_stage = 8'h00;
    end else begin
      bit old_run, step, hit;
      old_run = m_run;
      step = m_run && tick_en && (m_cnt >= TPS - 1);
      hit = m_auto && m_min == 0 && m_sec == 0;
      if (m_snapreq) begin
        s_sec = m_sec; s_min = m_min; s_hr = m_hr; s_day = m_day; s_mon = m_mon; s_yr = m_yr;
        m_snapreq = 0;
      end
      if (m_run && tick_en) m_cnt = step ? (hit ? m_comp : 0) : m_cnt + 1;
      if (step) begin
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
              m_hr = 0; m_day++;
              if (m_day > mdays(m_mon, m_yr)) begin
                m_day = 1; m_mon++;
                if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
              end
            end
          end
        end
      end
      if (wr_en) begin
        case (addr)
          4'd0: if (!old_run) m_sec = frombcd(wr_data);
          4'd1: if (!old_run) m_min = frombcd(wr_data);
          4'd2: if (!old_run) m_hr  = frombcd(wr_data);
          4'd3: if (!old_run) m_day = frombcd(wr_data);
          4'd4: if (!old_run) m_mon = frombcd(wr_data);
          4'd5: if (!old_run) m_yr  = frombcd(wr_data);
          4'd6: begin m_run = wr_data[0]; m_auto = wr_data[2]; if (wr_data[1]) m_snapreq = 1; end
          4'd7: m_stage = wr_data;
          4'd8: if ({wr_data, m_stage} != 16'h7FFF) m_comp = int'($signed({wr_data, m_stage}));
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    logic [15:0] c;
    c = m_comp[15:0];
    case (a)
      4'd0: return tobcd(s_sec);
      4'd1: return tobcd(s_min);
      4'd2: return tobcd(s_hr);
      4'd3: return tobcd(s_day);
      4'd4: return tobcd(s_mon);
      4'd5: return tobcd(s_yr);
      4'd6: return {5'b0, m_auto, m_snapreq, m_run};
      4'd7: return c[7:0];
      4'd8: return c[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (cmp_on && !done) begin
      logic [7:0] e;
      e = exp_rd(addr);
      n_cmp++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h t=%0t", cur_req, addr, rd_data, e, $time);
      end
    end
  end

  task automatic drive(logic [3:0] a, logic we, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d;
    tick_en = (tick_gap == 0) ? 1'b1 : ((tcount % tick_gap) != 0);
    tcount++;
  endtask

  task automatic run_snap(int n);
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0) drive(4'd6, 1'b1, {5'b0, b_auto, 1'b1, b_run});
      else begin drive(4'(rot), 1'b0, 8'h00); rot = (rot + 1) % 10; end
    end
  endtask

  task automatic set_ctrl(bit r, bit a);
    b_run = r; b_auto = a;
    drive(4'd6, 1'b1, {5'b0, a, 1'b0, r});
  endtask

  task automatic set_time(int y, int mo, int d, int h, int mi, int s);
    set_ctrl(0, b_auto);
    drive(4'd0, 1'b1, tobcd(s));
    drive(4'd1, 1'b1, tobcd(mi));
    drive(4'd2, 1'b1, tobcd(h));
    drive(4'd3, 1'b1, tobcd(d));
    drive(4'd4, 1'b1, tobcd(mo));
    drive(4'd5, 1'b1, tobcd(y));
    run_snap(4);
    set_ctrl(1, b_auto);
  endtask

  task automatic set_comp(logic [15:0] v);
    drive(4'd7, 1'b1, v[7:0]);
    drive(4'd8, 1'b1, v[15:8]);
    drive(4'd7, 1'b0, 8'h00);
    drive(4'd8, 1'b0, 8'h00);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    cur_req = "R9";
    for (int a = 0; a < 10; a++) drive(4'(a), 1'b0, 8'h00);

    cur_req = "R5";
    set_time(99, 12, 31, 23, 59, 56);
    drive(4'd0, 1'b1, 8'h30);
    drive(4'd4, 1'b1, 8'h05);
    run_snap(6);

    cur_req = "R4";
    run_snap(60);

    cur_req = "R1";
    tick_gap = 3;
    run_snap(40);
    set_ctrl(0, 0);
    run_snap(10);
    set_ctrl(1, 0);
    tick_gap = 0;

    cur_req = "R2";
    set_time(10, 6, 15, 9, 59, 58);
    run_snap(30);

    cur_req = "R3";
    set_time(23, 2, 28, 23, 59, 58);
    run_snap(20);
    set_time(24, 2, 28, 23, 59, 58);
    run_snap(20);
    set_time(24, 2, 29, 23, 59, 58);
    run_snap(20);
    set_time(31, 4, 30, 23, 59, 58);
    run_snap(20);
    set_time(31, 1, 31, 23, 59, 58);
    run_snap(20);
    set_time(31, 11, 30, 23, 59, 58);
    run_snap(20);

    cur_req = "R7";
    set_comp(16'h0002);
    set_comp(16'h7FFF);
    set_comp(16'h7FFE);
    set_comp(16'h0002);
    drive(4'd9, 1'b0, 8'h00);
    drive(4'd15, 1'b0, 8'h00);

    cur_req = "R8";
    set_time(30, 7, 4, 10, 59, 58);
    run_snap(40);
    b_auto = 1;
    set_time(30, 7, 4, 10, 59, 58);
    run_snap(50);
    set_comp(16'hFFFD);
    set_time(30, 7, 4, 11, 59, 58);
    run_snap(60);
    set_comp(16'h7FFE);
    set_time(30, 7, 4, 12, 59, 58);
    run_snap(40);
    set_time(30, 7, 4, 12, 30, 58);
    run_snap(30);

    cur_req = "R6";
    set_ctrl(0, 0);
    drive(4'd6, 1'b1, 8'h02);
    drive(4'd6, 1'b0, 8'h00);
    drive(4'd6, 1'b0, 8'h00);
    for (int a = 0; a < 6; a++) drive(4'(a), 1'b0, 8'h00);

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule